// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides a 32-bit unsigned dividend by an unsigned divisor whose value stays below 2^31. It returns a 32-bit quotient and a 32-bit remainder. It works over several clock cycles: a single pulse on `start` loads the operands, and one iteration of non-restoring division then runs on each clock. When the result is ready, `done` pulses for one cycle.

The partial remainder and the quotient share one double-width register pair. Each step first adds the divisor to the partial remainder or subtracts it, as the low quotient bit selects. It then rotates the pair left by one place. The top bit that wraps around is inverted before it lands in the quotient's least significant position. That inverted bit is the next quotient bit, and it also sets the direction of the next add or subtract. Loading performs one such rotation ahead of the loop.

After the last step, a fix-up cycle undoes the doubling left over from the final rotation. It adds the divisor back once if the partial remainder is negative. A zero divisor raises a flag alongside the result, and the quotient and remainder values are then meaningless.

Top module: `divmob_divider`

## Requirements
- R1: While reset is held and after its release, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all 0.
- R2: `start` high in a cycle where `busy` is low captures `dividend` and `divisor` on that clock edge, and `busy` is high in the next cycle.
- R3: `done` is high for exactly one cycle, 33 clock edges after the edge that accepted `start`. `busy` is low whenever `done` is high.
- R4: For a divisor from 1 to 2^31-1, `quotient` equals the floor of dividend / divisor when `done` is high.
- R5: For a divisor from 1 to 2^31-1, `remainder` equals dividend mod divisor when `done` is high, and is therefore strictly below the divisor.
- R6: `start` and operand changes while `busy` is high are ignored: the result and the timing of `done` belong to the accepted operands.
- R7: A zero divisor makes `div_by_zero` 1 in the `done` cycle. A later division with a nonzero divisor returns it to 0.
- R8: `quotient`, `remainder` and `div_by_zero` hold their values in every cycle in which `done` is low.
- R9: `start` asserted in the cycle where `done` is high is accepted, and a new division begins at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division while idle |
| dividend | input | 32 | Unsigned dividend |
| divisor | input | 32 | Unsigned divisor, below 2^31 |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle result-valid pulse |
| quotient | output | 32 | Result quotient |
| remainder | output | 32 | Result remainder |
| div_by_zero | output | 1 | Divisor was zero for this result |

## Verification
`busy` is due one edge after the edge that accepts `start`. The result, `div_by_zero` and the `done` pulse are due together, 33 edges after that acceptance. The bench drives inputs on falling edges and then counts falling edges one by one. It checks that `done` stays low for the first 32 of them and samples every result at exactly the 33rd. The back-to-back and hold tests start counting from that same point, so each later expectation falls on a known cycle.

// File: rtl/divmob_pkg.sv
package divmob_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divmob_state_t;
endpackage

// File: rtl/divmob_step.sv
module divmob_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dsr_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  // subtract when the low quotient bit says the remainder was non-negative
  function automatic logic [W-1:0] add_or_sub(input logic [W-1:0] r,
                                              input logic [W-1:0] d,
                                              input logic         sub);
    return sub ? (r - d) : (r + d);
  endfunction

  // rotate the pair left, inverting the bit that wraps around
  function automatic logic [2*W-1:0] mobius(input logic [2*W-1:0] pair);
    return {pair[2*W-2:0], ~pair[2*W-1]};
  endfunction

  logic [W-1:0] sum;

  always_comb begin
    sum            = add_or_sub(rem_i, dsr_i, quo_i[0]);
    {rem_o, quo_o} = mobius({sum, quo_i});
  end
endmodule

// File: rtl/divmob_fix.sv
module divmob_fix #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] dsr_i,
  output logic [W-1:0] rem_o
);
  // undo the last doubling: the lost sign is the inverse of the last quotient bit
  function automatic logic [W-1:0] unshift(input logic [W-1:0] r, input logic q0);
    return {~q0, r[W-1:1]};
  endfunction

  logic [W-1:0] partial;

  always_comb begin
    partial = unshift(rem_i, quo_i[0]);
    rem_o   = quo_i[0] ? partial : (partial + dsr_i);
  end
endmodule

// File: rtl/divmob_ctrl.sv
module divmob_ctrl
  import divmob_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic fix_en,
  output logic busy,
  output logic done
);
  localparam int CW = $clog2(W + 1);

  divmob_state_t state;
  logic [CW-1:0] cnt;

  assign load    = start && (state == ST_IDLE);
  assign step_en = (state == ST_RUN);
  assign fix_en  = (state == ST_FIX);
  assign busy    = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= fix_en;
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_RUN;
          cnt   <= CW'(W);
        end
        ST_RUN: begin
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) state <= ST_FIX;
        end
        ST_FIX:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !fix_en) |=> busy);
endmodule

// File: rtl/divmob_divider.sv
module divmob_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  localparam int LW = $clog2(W + 2);

  logic         load, step_en, fix_en;
  logic [W-1:0] rem_r, quo_r, dsr_r, dvd_r;
  logic [W-1:0] rem_nx, quo_nx, rem_fixed;
  logic [LW-1:0] lat_cnt;

  divmob_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step_en(step_en), .fix_en(fix_en),
    .busy(busy), .done(done)
  );

  divmob_step #(.W(W)) u_step (
    .rem_i(rem_r), .quo_i(quo_r), .dsr_i(dsr_r),
    .rem_o(rem_nx), .quo_o(quo_nx)
  );

  divmob_fix #(.W(W)) u_fix (
    .rem_i(rem_r), .quo_i(quo_r), .dsr_i(dsr_r),
    .rem_o(rem_fixed)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_r       <= '0;
      quo_r       <= '0;
      dsr_r       <= '0;
      dvd_r       <= '0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else if (load) begin
      // zero remainder, quotient = dividend, then one leading rotation
      rem_r <= {{(W-1){1'b0}}, dividend[W-1]};
      quo_r <= {dividend[W-2:0], 1'b1};
      dsr_r <= divisor;
      dvd_r <= dividend;
    end else if (step_en) begin
      rem_r <= rem_nx;
      quo_r <= quo_nx;
    end else if (fix_en) begin
      quotient    <= quo_r;
      remainder   <= rem_fixed;
      div_by_zero <= (dsr_r == '0);
    end
  end

  // cycle counter used only by the latency check
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lat_cnt <= '0;
    else if (load)    lat_cnt <= '0;
    else if (busy)    lat_cnt <= lat_cnt + 1'b1;
  end

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (lat_cnt == LW'(W + 1)));
  assert_product_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |->
      ({{W{1'b0}}, quotient} * {{W{1'b0}}, dsr_r} + {{W{1'b0}}, remainder}
        == {{W{1'b0}}, dvd_r}));
  assert_rem_below_divisor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (remainder < dsr_r));
  assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (div_by_zero == (dsr_r == '0)));
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
endmodule

// File: tb/divmob_divider_test.sv
module divmob_divider_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] dividend = '0;
  logic [31:0] divisor = '0;
  logic        busy, done, div_by_zero;
  logic [31:0] quotient, remainder;

  int checks = 0;
  int failures = 0;

  divmob_divider uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient),
    .remainder(remainder), .div_by_zero(div_by_zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive start on a falling edge; return after the accepting edge
  task automatic launch(input logic [31:0] a, input logic [31:0] b);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after accept", {63'b0, busy}, 64'd1);
  endtask

  // count edges to completion and check the result on the 33rd
  task automatic finish(input logic [31:0] a, input logic [31:0] b, input bit noise);
    for (int k = 1; k <= 33; k++) begin
      if (noise && k >= 5 && k <= 7) begin
        start    = 1'b1;
        dividend = 32'hDEAD_BEEF;
        divisor  = 32'd3;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      if (k < 33 && done !== 1'b0)
        chk(1'b0, noise ? "R6 early done" : "R3 early done", {63'b0, done}, 64'd0);
    end
    start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, noise ? "R6 done timing" : "R3 done timing",
        {62'b0, done, busy}, 64'd2);
    chk(div_by_zero === (b == 0), "R7 zero flag", {63'b0, div_by_zero}, {63'b0, b == 0});
    if (b != 0) begin
      chk(quotient === a / b, noise ? "R6 quotient" : "R4 quotient", quotient, a / b);
      chk(remainder === a % b, noise ? "R6 remainder" : "R5 remainder", remainder, a % b);
    end
  endtask

  task automatic divide(input logic [31:0] a, input logic [31:0] b);
    launch(a, b);
    finish(a, b, 1'b0);
    @(negedge clk);
    chk(done === 1'b0, "R3 done one cycle", {63'b0, done}, 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({busy, done, div_by_zero} === 3'b000, "R1 flags in reset",
        {61'b0, busy, done, div_by_zero}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(quotient === 0 && remainder === 0 && busy === 0 && done === 0,
        "R1 outputs after reset", {quotient, remainder}, 64'd0);
  endtask

  task automatic t_corners();
    divide(32'h0000_0000, 32'd1);
    divide(32'hFFFF_FFFF, 32'd1);
    divide(32'h0000_0000, 32'd7);
    divide(32'hFFFF_FFFF, 32'h7FFF_FFFF);
    divide(32'hFFFF_FFFF, 32'd7);
    divide(32'd5, 32'd7);
    divide(32'h7FFF_FFFF, 32'h7FFF_FFFF);
    divide(32'h8000_0000, 32'h4000_0000);
    divide(32'd100, 32'd10);
  endtask

  task automatic t_random();
    for (int i = 0; i < 40; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = $urandom & 32'h7FFF_FFFF;
      if (i % 3 == 0) b = b & 32'h0000_FFFF;
      if (b == 0) b = 32'd13;
      divide(a, b);
    end
  endtask

  task automatic t_zero_div();
    divide(32'd99, 32'd0);
    divide(32'd99, 32'd4);
  endtask

  task automatic t_busy_ignore();
    launch(32'h1234_5678, 32'd1000);
    finish(32'h1234_5678, 32'd1000, 1'b1);
    @(negedge clk);
  endtask

  task automatic t_back_to_back();
    launch(32'hCAFE_F00D, 32'd77);
    finish(32'hCAFE_F00D, 32'd77, 1'b0);
    launch(32'd1_000_000, 32'd999);
    chk(1'b1, "R9 second accepted", 64'd0, 64'd0);
    finish(32'd1_000_000, 32'd999, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_hold();
    logic [31:0] q0, r0;
    launch(32'd4321, 32'd17);
    finish(32'd4321, 32'd17, 1'b0);
    q0 = quotient;
    r0 = remainder;
    dividend = 32'hFFFF_0000;
    divisor  = 32'd5;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(quotient === q0 && remainder === r0 && done === 1'b0, "R8 hold",
          {quotient, remainder}, {q0, r0});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_corners();
    t_random();
    t_zero_div();
    t_busy_ignore();
    t_back_to_back();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule